// File: doc/BRIEF.md
# Streaming Colour Palette with Auto-Advancing Write Port

This block holds a 256-entry RGB colour table. A CPU loads it over its I/O bus through two write-only ports, while the video pipeline reads it through a separate registered port. The video side can read at any time, including while the CPU is writing.

One port selects the colour slot. The other port accepts component levels in a fixed rotation: red, then green, then blue. After the blue write, the slot number advances by one on its own. A program can therefore set a starting slot once and then load any number of consecutive colours by writing bytes to a single port.

After reset every entry is black. Both ports are matched against the full 16-bit I/O address.

Top module: `palette_loader`

## Requirements
- R1: After reset deassertion every entry reads back as black (all 24 bits zero) and the slot counter and component phase are zero/red.
- R2: A write (io_wr_i high) with io_addr_i equal to 16'hBE3B loads the slot counter with io_data_i.
- R3: Writes with io_addr_i equal to 16'hFE3B store io_data_i into the red, green and blue field of the current slot, in that order; vid_rgb_o packs red in bits 23:16, green in 15:8 and blue in 7:0.
- R4: The data-port write that stores blue also advances the slot counter by one, so the next data-port write stores red of the following slot.
- R5: The slot counter wraps from 255 to 0 when it advances.
- R6: A slot-port write returns the component phase to red, discarding any partly written colour sequence.
- R7: Writes to any other address, and any cycle with io_wr_i low, leave the palette, slot counter and phase unchanged.
- R8: vid_rgb_o shows the entry addressed by vid_idx_i at the preceding rising clock edge, one cycle of latency.
- R9: When a data-port write and a video read target the same entry on the same edge, the video port returns the value before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| io_wr_i | input | 1 | CPU I/O write strobe, one cycle per write |
| io_addr_i | input | 16 | CPU I/O port address |
| io_data_i | input | 8 | CPU I/O write data |
| vid_idx_i | input | 8 | Video read slot |
| vid_rgb_o | output | 24 | Registered RGB of the slot, red in the top byte |

## Verification
The bench targets wrap-around at slot 255. A design that misses it would put the next colour into a slot of a wider counter or would stall. It also targets a slot-port write issued in the middle of a colour sequence. A design that does not reset the phase would file the next byte as green or blue.

Writes to near-miss addresses, and a data-port address with the strobe low, are checked to leave the stream position untouched. A decoder that ignores some address bits, or the strobe, would shift every following byte by one component. A write and a read of the same slot on one edge must return the old colour. A write-first store would show the new red a cycle early. Streaming eight colours in a row from one slot write catches any error in the phase rotation.

// File: rtl/palette_pkg.sv
package palette_pkg;
  typedef enum logic [1:0] {
    PH_RED   = 2'd0,
    PH_GREEN = 2'd1,
    PH_BLUE  = 2'd2
  } phase_e;

  localparam logic [15:0] SLOT_PORT_DEF = 16'hBE3B;
  localparam logic [15:0] DATA_PORT_DEF = 16'hFE3B;
endpackage

// File: rtl/palette_io_decode.sv
module palette_io_decode #(
  parameter logic [15:0] INDEX_PORT = 16'hBE3B,
  parameter logic [15:0] DATA_PORT  = 16'hFE3B
) (
  input  logic        wr_i,
  input  logic [15:0] addr_i,
  output logic        slot_wr_o,
  output logic        data_wr_o
);
  // full 16-bit match; no partial decode
  assign slot_wr_o = wr_i && (addr_i == INDEX_PORT);
  assign data_wr_o = wr_i && (addr_i == DATA_PORT);
endmodule

// File: rtl/palette_write_seq.sv
module palette_write_seq
  import palette_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slot_wr_i,
  input  logic              data_wr_i,
  input  logic [COMP_W-1:0] data_i,
  output logic [IDX_W-1:0]  idx_o,
  output phase_e            phase_o
);
  logic [IDX_W-1:0] idx_q;
  phase_e           phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q   <= '0;
      phase_q <= PH_RED;
    end else if (slot_wr_i) begin
      idx_q   <= IDX_W'(data_i);
      phase_q <= PH_RED;
    end else if (data_wr_i) begin
      unique case (phase_q)
        PH_RED:   phase_q <= PH_GREEN;
        PH_GREEN: phase_q <= PH_BLUE;
        default: begin
          phase_q <= PH_RED;
          idx_q   <= idx_q + 1'b1; // natural wrap
        end
      endcase
    end
  end

  assign idx_o   = idx_q;
  assign phase_o = phase_q;
endmodule

// File: rtl/palette_store.sv
module palette_store
  import palette_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [IDX_W-1:0]    waddr_i,
  input  phase_e              comp_i,
  input  logic [COMP_W-1:0]   wdata_i,
  input  logic [IDX_W-1:0]    raddr_i,
  output logic [3*COMP_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int RGB_W = 3 * COMP_W;

  logic [RGB_W-1:0] entry_q [DEPTH];
  logic [RGB_W-1:0] rd_q;

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    logic hit;
    assign hit = we_i && (waddr_i == IDX_W'(e));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        entry_q[e] <= '0;
      end else if (hit) begin
        unique case (comp_i)
          PH_RED:   entry_q[e][2*COMP_W +: COMP_W] <= wdata_i;
          PH_GREEN: entry_q[e][COMP_W   +: COMP_W] <= wdata_i;
          default:  entry_q[e][0        +: COMP_W] <= wdata_i;
        endcase
      end
    end
  end

  // read-before-write: captures pre-edge contents
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= '0;
    else         rd_q <= entry_q[raddr_i];
  end

  assign rdata_o = rd_q;
endmodule

// File: rtl/palette_loader.sv
module palette_loader
  import palette_pkg::*;
#(
  parameter int          IDX_W      = 8,
  parameter int          COMP_W     = 8,
  parameter logic [15:0] INDEX_PORT = SLOT_PORT_DEF,
  parameter logic [15:0] DATA_PORT  = DATA_PORT_DEF
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                io_wr_i,
  input  logic [15:0]         io_addr_i,
  input  logic [COMP_W-1:0]   io_data_i,
  input  logic [IDX_W-1:0]    vid_idx_i,
  output logic [3*COMP_W-1:0] vid_rgb_o
);
  logic             slot_wr, data_wr;
  logic [IDX_W-1:0] cur_idx;
  phase_e           cur_phase;

  palette_io_decode #(
    .INDEX_PORT(INDEX_PORT),
    .DATA_PORT (DATA_PORT)
  ) u_dec (
    .wr_i     (io_wr_i),
    .addr_i   (io_addr_i),
    .slot_wr_o(slot_wr),
    .data_wr_o(data_wr)
  );

  palette_write_seq #(
    .IDX_W (IDX_W),
    .COMP_W(COMP_W)
  ) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .slot_wr_i(slot_wr),
    .data_wr_i(data_wr),
    .data_i   (io_data_i),
    .idx_o    (cur_idx),
    .phase_o  (cur_phase)
  );

  palette_store #(
    .IDX_W (IDX_W),
    .COMP_W(COMP_W)
  ) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (data_wr),
    .waddr_i(cur_idx),
    .comp_i (cur_phase),
    .wdata_i(io_data_i),
    .raddr_i(vid_idx_i),
    .rdata_o(vid_rgb_o)
  );
endmodule

// File: rtl/palette_loader_chk.sv
module palette_loader_chk #(
  parameter int          IDX_W      = 8,
  parameter int          COMP_W     = 8,
  parameter logic [15:0] INDEX_PORT = 16'hBE3B,
  parameter logic [15:0] DATA_PORT  = 16'hFE3B
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              io_wr_i,
  input logic [15:0]       io_addr_i,
  input logic [COMP_W-1:0] io_data_i,
  input logic [IDX_W-1:0]  cur_idx,
  input logic [1:0]        cur_phase
);
  logic slot_hit, data_hit;
  assign slot_hit = io_wr_i && (io_addr_i == INDEX_PORT);
  assign data_hit = io_wr_i && (io_addr_i == DATA_PORT);

  assert_phase_legal_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_phase != 2'd3);

  assert_slot_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_hit |=> cur_idx == IDX_W'($past(io_data_i)));

  assert_red_to_green_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_hit && cur_phase == 2'd0) |=> (cur_phase == 2'd1 && $stable(cur_idx)));

  assert_advance_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_hit && cur_phase == 2'd2) |=> (cur_idx == IDX_W'($past(cur_idx) + 1'b1) && cur_phase == 2'd0));

  assert_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_hit && cur_phase == 2'd2 && cur_idx == '1) |=> cur_idx == '0);

  assert_phase_reset_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_hit |=> cur_phase == 2'd0);

  assert_ignore_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(slot_hit || data_hit) |=> ($stable(cur_idx) && $stable(cur_phase)));
endmodule

bind palette_loader palette_loader_chk #(
  .IDX_W     (IDX_W),
  .COMP_W    (COMP_W),
  .INDEX_PORT(INDEX_PORT),
  .DATA_PORT (DATA_PORT)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .io_wr_i  (io_wr_i),
  .io_addr_i(io_addr_i),
  .io_data_i(io_data_i),
  .cur_idx  (cur_idx),
  .cur_phase(cur_phase)
);

// File: tb/palette_loader_tb.sv
module palette_loader_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] P_SLOT = 16'hBE3B;
  localparam logic [15:0] P_DATA = 16'hFE3B;

  typedef struct {
    string       tag;
    logic [7:0]  idx;
    logic [23:0] exp;
  } item_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        io_wr_i = 1'b0;
  logic [15:0] io_addr_i = '0;
  logic [7:0]  io_data_i = '0;
  logic [7:0]  vid_idx_i = '0;
  logic [23:0] vid_rgb_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  item_t       sb_q[$];
  logic [23:0] model [256];
  logic [7:0]  m_idx = '0;
  int          m_ph = 0;

  palette_loader u_dut (
    .clk_i, .rst_ni, .io_wr_i, .io_addr_i, .io_data_i, .vid_idx_i, .vid_rgb_o
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic void model_io(input logic [15:0] a, input logic [7:0] d);
    if (a == P_SLOT) begin
      m_idx = d; m_ph = 0;
    end else if (a == P_DATA) begin
      case (m_ph)
        0: model[m_idx][23:16] = d;
        1: model[m_idx][15:8]  = d;
        default: model[m_idx][7:0] = d;
      endcase
      if (m_ph == 2) begin m_ph = 0; m_idx = m_idx + 8'd1; end
      else m_ph = m_ph + 1;
    end
  endfunction

  task automatic io_write(input logic [15:0] a, input logic [7:0] d, input bit strobe = 1);
    @(negedge clk_i);
    io_wr_i = strobe; io_addr_i = a; io_data_i = d;
    if (strobe) model_io(a, d);
    @(negedge clk_i);
    io_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] i, input string tag);
    item_t it;
    @(negedge clk_i);
    vid_idx_i = i;
    it.tag = tag; it.idx = i; it.exp = model[i];
    sb_q.push_back(it);
  endtask

  // same edge: data write to current slot and video read of it
  task automatic collide(input logic [7:0] d, input string tag);
    item_t it;
    @(negedge clk_i);
    vid_idx_i = m_idx;
    it.tag = tag; it.idx = m_idx; it.exp = model[m_idx];
    sb_q.push_back(it);
    io_wr_i = 1'b1; io_addr_i = P_DATA; io_data_i = d;
    model_io(P_DATA, d);
    @(negedge clk_i);
    io_wr_i = 1'b0;
  endtask

  // monitor: result registered at edge, sampled just after it
  always @(posedge clk_i) begin
    #1;
    if (sb_q.size() != 0) begin
      item_t it;
      it = sb_q.pop_front();
      checks++;
      if (vid_rgb_o !== it.exp) begin
        errors++;
        $display("FAIL %s slot %0d actual %h expected %h", it.tag, it.idx, vid_rgb_o, it.exp);
      end
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) model[i] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1: reset contents black
    rd(8'd0, "R1"); rd(8'd255, "R1"); rd(8'd77, "R1");

    // R2, R3: slot load and RGB order / packing
    io_write(P_SLOT, 8'd5);
    io_write(P_DATA, 8'h11); io_write(P_DATA, 8'h22); io_write(P_DATA, 8'h33);
    rd(8'd5, "R2_R3 rgb order");

    // R4: stream continues into next slot
    io_write(P_DATA, 8'h44); io_write(P_DATA, 8'h55); io_write(P_DATA, 8'h66);
    rd(8'd6, "R4 auto advance");
    rd(8'd5, "R4 prior slot kept");

    // R5: wrap 255 -> 0
    io_write(P_SLOT, 8'd255);
    io_write(P_DATA, 8'hA1); io_write(P_DATA, 8'hA2); io_write(P_DATA, 8'hA3);
    io_write(P_DATA, 8'hB1); io_write(P_DATA, 8'hB2); io_write(P_DATA, 8'hB3);
    rd(8'd255, "R5 last slot"); rd(8'd0, "R5 wrapped slot");

    // R6: slot write mid-sequence restarts at red
    io_write(P_SLOT, 8'd10);
    io_write(P_DATA, 8'hEE); io_write(P_DATA, 8'hDD);
    io_write(P_SLOT, 8'd10);
    io_write(P_DATA, 8'h07); io_write(P_DATA, 8'h08); io_write(P_DATA, 8'h09);
    rd(8'd10, "R6 phase reset"); rd(8'd11, "R6 no spill");

    // R7: near-miss addresses and strobe low ignored
    io_write(P_SLOT, 8'd30);
    io_write(P_DATA, 8'hAA);
    io_write(16'hFE3A, 8'h99);
    io_write(16'h7E3B, 8'h98);
    io_write(16'h3E3B, 8'h97);
    io_write(P_DATA, 8'h77, 0);
    io_write(P_SLOT, 8'h40, 0);
    io_write(P_DATA, 8'hBB); io_write(P_DATA, 8'hCC);
    rd(8'd30, "R7 ignored writes"); rd(8'd31, "R7 neighbour untouched");

    // R9: write and read same slot on one edge -> old value
    io_write(P_SLOT, 8'd40);
    io_write(P_DATA, 8'h01); io_write(P_DATA, 8'h02); io_write(P_DATA, 8'h03);
    io_write(P_SLOT, 8'd40);
    collide(8'h50, "R9 old value on collision");
    rd(8'd40, "R9 new value next cycle");

    // R8 + R4: stream eight colours, back-to-back reads one per cycle
    io_write(P_SLOT, 8'd100);
    for (int c = 0; c < 24; c++) io_write(P_DATA, 8'(c * 7 + 3));
    for (int i = 100; i < 108; i++) rd(8'(i), "R8_R4 stream readback");
    rd(8'd108, "R8 beyond stream");

    repeat (3) @(negedge clk_i);
    if (sb_q.size() != 0) begin
      errors++;
      $display("FAIL R8 pending results actual %0d expected 0", sb_q.size());
    end
    finish_run();
  end
endmodule